// File: doc/BRIEF.md
# Light Threshold Alarm with Persistence Filter

This block sits behind a light sensor's converter. It looks at each finished measurement, marked by a one-cycle valid strobe, and decides whether the light level has left a window set by two 8-bit limits. A reading counts as out of window when its top byte is above the upper limit or below the lower limit. A persistence filter counts consecutive out-of-window readings. The alarm is raised only when the count reaches the number picked by a 2-bit setting. A brief spike, such as a camera flash, therefore does not trip it.

Once raised, the alarm flag stays latched until software sends a clear request. The flag also drives an open-drain pull-down enable. When that enable is high, the external active-low interrupt line is pulled to zero.

Control is a three-state machine. In WATCH no run is in progress. In COUNT a run of out-of-window readings is being counted. In ALARM the flag is latched. The transitions are:
- start_run: WATCH to COUNT.
- spike_trip: WATCH to ALARM, when one reading is enough.
- run_broken: COUNT to WATCH, on an in-window reading.
- run_complete: COUNT to ALARM.
- acknowledge: ALARM to WATCH or COUNT, on a clear request.
- re_arm: ALARM stays in ALARM when a clear request meets a reading that alone trips the alarm again.

Top module: `lux_alarm_filter`

## Requirements
- R1: A synchronous reset sets irq_flag and irq_pulldown_en to 0 and empties the run count.
- R2: A measurement is out of window when meas_value[15:8] is greater than thr_upper or less than thr_lower. A top byte equal to either limit is inside the window.
- R3: persist_sel selects the run length needed to trip the alarm: 0 selects 1, 1 selects 4, 2 selects 8 and 3 selects 16 consecutive out-of-window results.
- R4: Any valid in-window result sets the run count back to zero.
- R5: Only cycles with meas_valid high change the run count. Idle cycles between results neither add to the run nor break it.
- R6: Once set, irq_flag stays at 1 until a clear request, even if later results are in the window.
- R7: clear_req sets irq_flag to 0 on the next cycle. A valid result in the same cycle as the clear is taken as the first result of a new run. With a run length of 1 and an out-of-window result, the flag therefore stays at 1.
- R8: irq_pulldown_en is 1 exactly when irq_flag is 1, so the active-low line is low only while the alarm is latched.
- R9: irq_flag rises on the clock edge that takes in the result completing the run. It reads 1 in the cycle after that strobe.
- R10: Results taken in while the alarm is latched and no clear is present are ignored. After a clear, a full new run is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| meas_value | input | 16 | Finished light measurement |
| meas_valid | input | 1 | One-cycle strobe marking a new measurement |
| thr_upper | input | 8 | Upper window limit, compared with the top byte |
| thr_lower | input | 8 | Lower window limit, compared with the top byte |
| persist_sel | input | 2 | Run-length select (1, 4, 8, 16) |
| clear_req | input | 1 | Clears the latched alarm and the run |
| irq_flag | output | 1 | Latched alarm flag |
| irq_pulldown_en | output | 1 | Open-drain enable; when high the interrupt line is driven to zero |

## Verification
A clear request and an incoming result can land in the same cycle. The bench forces this on purpose in two ways. It sends an out-of-window strobe together with clear_req while the alarm is latched and the run length is 1, and expects the flag to stay high. It repeats this with a run length of 4, and expects the flag to drop and then rise after three more out-of-window results. The random phase also lets clear requests and strobes coincide freely. Each outcome is judged against a bench model in which the clear acts first and the same-cycle result opens a new run.

// File: rtl/lux_alarm_pkg.sv
package lux_alarm_pkg;

    typedef enum logic [1:0] {
        S_WATCH = 2'd0,
        S_COUNT = 2'd1,
        S_ALARM = 2'd2
    } alarm_state_t;

    localparam int SEL_W   = 2;
    localparam int MAX_RUN = 2 << ((1 << SEL_W) - 1);

    // 0 -> 1, 1 -> 4, 2 -> 8, 3 -> 16
    function automatic int unsigned run_needed(input logic [SEL_W-1:0] sel);
        int unsigned n;
        if (sel == '0) n = 1;
        else           n = 2 << sel;
        return n;
    endfunction

endpackage

// File: rtl/lux_window_cmp.sv
module lux_window_cmp #(
    parameter int MEAS_W = 16,
    parameter int THR_W  = 8
) (
    input  logic [MEAS_W-1:0] meas,
    input  logic [THR_W-1:0]  upper,
    input  logic [THR_W-1:0]  lower,
    output logic              outside
);
    localparam int FILL_W = MEAS_W - THR_W;

    logic [MEAS_W-1:0] upper_edge;
    logic [MEAS_W-1:0] lower_edge;

    // Top-byte compare, done on the full value so that every bit is used:
    // top > upper  <=>  meas > {upper, all ones}
    // top < lower  <=>  meas < {lower, all zeros}
    generate
        if (FILL_W == 0) begin : g_direct
            assign upper_edge = upper;
            assign lower_edge = lower;
        end else begin : g_scaled
            assign upper_edge = {upper, {FILL_W{1'b1}}};
            assign lower_edge = {lower, {FILL_W{1'b0}}};
        end
    endgenerate

    always_comb begin
        outside = (meas > upper_edge) || (meas < lower_edge);
    end

endmodule

// File: rtl/lux_run_counter.sv
module lux_run_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    input  logic             hit,
    output logic [CNT_W-1:0] run_next
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] base;

    always_comb begin
        base     = restart ? '0 : run_q;
        run_next = base;
        if (tick) begin
            if (!hit)                run_next = '0;
            else if (base == CNT_MAX) run_next = CNT_MAX;
            else                     run_next = base + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) run_q <= '0;
        else     run_q <= run_next;
    end

endmodule

// File: rtl/lux_alarm_fsm.sv
module lux_alarm_fsm
    import lux_alarm_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic             hit,
    input  logic             clear,
    input  logic [CNT_W-1:0] need,
    input  logic [CNT_W-1:0] run_next,
    output logic             cnt_restart,
    output logic             cnt_tick,
    output logic             flag
);
    alarm_state_t state_q;
    alarm_state_t state_d;
    logic         reach;

    always_ff @(posedge clk) begin
        if (rst) state_q <= S_WATCH;
        else     state_q <= state_d;
    end

    always_comb begin
        cnt_restart = clear || (state_q == S_ALARM);
        cnt_tick    = strobe && ((state_q != S_ALARM) || clear);
        reach       = cnt_tick && hit && (run_next >= need);
        state_d     = state_q;
        unique case (state_q)
            S_WATCH: begin
                if (reach)              state_d = S_ALARM;  // spike_trip
                else if (run_next != 0) state_d = S_COUNT;  // start_run
            end
            S_COUNT: begin
                if (reach)              state_d = S_ALARM;  // run_complete
                else if (run_next == 0) state_d = S_WATCH;  // run_broken
            end
            S_ALARM: begin
                if (clear) begin
                    if (reach)              state_d = S_ALARM;  // re_arm
                    else if (run_next != 0) state_d = S_COUNT;  // acknowledge
                    else                    state_d = S_WATCH;  // acknowledge
                end
            end
            default: state_d = S_WATCH;
        endcase
    end

    always_comb begin
        flag = (state_q == S_ALARM);
    end

endmodule

// File: rtl/lux_alarm_filter.sv
module lux_alarm_filter
    import lux_alarm_pkg::*;
#(
    parameter int MEAS_W = 16,
    parameter int THR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MEAS_W-1:0] meas_value,
    input  logic              meas_valid,
    input  logic [THR_W-1:0]  thr_upper,
    input  logic [THR_W-1:0]  thr_lower,
    input  logic [SEL_W-1:0]  persist_sel,
    input  logic              clear_req,
    output logic              irq_flag,
    output logic              irq_pulldown_en
);
    localparam int CNT_W = $clog2(MAX_RUN + 1);

    logic             outside;
    logic             cnt_restart;
    logic             cnt_tick;
    logic [CNT_W-1:0] run_next;
    logic [CNT_W-1:0] need;
    logic             flag;

    always_comb begin
        need = CNT_W'(run_needed(persist_sel));
    end

    lux_window_cmp #(.MEAS_W(MEAS_W), .THR_W(THR_W)) u_cmp (
        .meas    (meas_value),
        .upper   (thr_upper),
        .lower   (thr_lower),
        .outside (outside)
    );

    lux_run_counter #(.CNT_W(CNT_W)) u_run (
        .clk      (clk),
        .rst      (rst),
        .restart  (cnt_restart),
        .tick     (cnt_tick),
        .hit      (outside),
        .run_next (run_next)
    );

    lux_alarm_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .strobe      (meas_valid),
        .hit         (outside),
        .clear       (clear_req),
        .need        (need),
        .run_next    (run_next),
        .cnt_restart (cnt_restart),
        .cnt_tick    (cnt_tick),
        .flag        (flag)
    );

    always_comb begin
        irq_flag        = flag;
        irq_pulldown_en = flag;
    end

endmodule

// File: rtl/lux_alarm_filter_chk.sv
module lux_alarm_filter_chk #(
    parameter int MEAS_W = 16,
    parameter int THR_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [MEAS_W-1:0] meas_value,
    input logic              meas_valid,
    input logic [THR_W-1:0]  thr_upper,
    input logic [THR_W-1:0]  thr_lower,
    input logic [1:0]        persist_sel,
    input logic              clear_req,
    input logic              irq_flag,
    input logic              irq_pulldown_en
);
    logic       oow;
    logic [4:0] run_c;
    logic [4:0] need_c;

    always_comb begin
        oow = (meas_value > {thr_upper, {(MEAS_W-THR_W){1'b1}}}) ||
              (meas_value < {thr_lower, {(MEAS_W-THR_W){1'b0}}});
        case (persist_sel)
            2'd0:    need_c = 5'd1;
            2'd1:    need_c = 5'd4;
            2'd2:    need_c = 5'd8;
            default: need_c = 5'd16;
        endcase
    end

    // Independent run length; never below the design's own count.
    always_ff @(posedge clk) begin
        if (rst) run_c <= '0;
        else if (clear_req) run_c <= (meas_valid && oow) ? 5'd1 : 5'd0;
        else if (meas_valid) begin
            if (!oow)               run_c <= '0;
            else if (run_c != 5'd31) run_c <= run_c + 5'd1;
        end
    end

    assert_reset_release_R1: assert property (@(posedge clk)
        rst |=> (!irq_flag && !irq_pulldown_en));

    assert_pin_follows_flag_R8: assert property (@(posedge clk) disable iff (rst)
        irq_pulldown_en == irq_flag);

    assert_rise_needs_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag) |-> ($past(meas_valid) && $past(oow)));

    assert_rise_needs_run_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag) |-> (run_c >= $past(need_c)));

    assert_latched_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !clear_req) |=> irq_flag);

    assert_clear_drops_R7: assert property (@(posedge clk) disable iff (rst)
        (clear_req && !(meas_valid && oow && persist_sel == 2'd0)) |=> !irq_flag);

    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (!meas_valid && !clear_req) |=> $stable(irq_flag));

endmodule

bind lux_alarm_filter lux_alarm_filter_chk #(.MEAS_W(MEAS_W), .THR_W(THR_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .meas_value      (meas_value),
    .meas_valid      (meas_valid),
    .thr_upper       (thr_upper),
    .thr_lower       (thr_lower),
    .persist_sel     (persist_sel),
    .clear_req       (clear_req),
    .irq_flag        (irq_flag),
    .irq_pulldown_en (irq_pulldown_en)
);

// File: tb/lux_alarm_filter_test.sv
`timescale 1ns/1ps
module lux_alarm_filter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] meas_value = '0;
    logic        meas_valid = 1'b0;
    logic [7:0]  thr_upper = 8'h80;
    logic [7:0]  thr_lower = 8'h20;
    logic [1:0]  persist_sel = 2'd0;
    logic        clear_req = 1'b0;
    logic        irq_flag;
    logic        irq_pulldown_en;

    int checks = 0;
    int errors = 0;
    bit m_flag = 1'b0;
    int m_run  = 0;

    always #10 clk = ~clk;

    lux_alarm_filter uut (
        .clk(clk), .rst(rst), .meas_value(meas_value), .meas_valid(meas_valid),
        .thr_upper(thr_upper), .thr_lower(thr_lower), .persist_sel(persist_sel),
        .clear_req(clear_req), .irq_flag(irq_flag), .irq_pulldown_en(irq_pulldown_en)
    );

    function automatic bit is_out(input logic [15:0] m, input logic [7:0] up, input logic [7:0] lo);
        return (m[15:8] > up) || (m[15:8] < lo);
    endfunction

    function automatic int needed(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 16;
        endcase
    endfunction

    task automatic model_edge();
        if (rst) begin
            m_flag = 1'b0; m_run = 0;
        end else begin
            if (clear_req) begin m_flag = 1'b0; m_run = 0; end
            else if (m_flag) m_run = 0;
            if (meas_valid && !m_flag) begin
                if (is_out(meas_value, thr_upper, thr_lower)) begin
                    m_run = (m_run < 31) ? m_run + 1 : 31;
                    if (m_run >= needed(persist_sel)) begin m_flag = 1'b1; m_run = 0; end
                end else m_run = 0;
            end
        end
    endtask

    task automatic check(input string tag);
        checks++;
        if (irq_flag !== m_flag) begin
            errors++;
            $display("FAIL %s: irq_flag actual %0b expected %0b", tag, irq_flag, m_flag);
        end
        checks++;
        if (irq_pulldown_en !== m_flag) begin
            errors++;
            $display("FAIL R8 (%s): irq_pulldown_en actual %0b expected %0b", tag, irq_pulldown_en, m_flag);
        end
    endtask

    task automatic step(input logic v, input logic [15:0] m, input logic c, input string tag);
        @(negedge clk);
        meas_valid = v; meas_value = m; clear_req = c;
        @(posedge clk);
        model_edge();
        #5;
        check(tag);
    endtask

    task automatic out_run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, 16'hC000 + 16'(i), 1'b0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rm;
        logic rv, rc;
        rm = 16'($urandom(32'd2024));
        rst = 1'b1;
        repeat (2) step(1'b0, 16'h0, 1'b0, "R1");
        rst = 1'b0;
        step(1'b0, 16'h0, 1'b0, "R1");

        // run length 1: single out-of-window result trips next cycle
        persist_sel = 2'd0;
        step(1'b1, 16'h8100, 1'b0, "R9");
        step(1'b1, 16'h5000, 1'b0, "R6");
        step(1'b0, 16'h0, 1'b0, "R6");
        step(1'b0, 16'h0, 1'b1, "R7");

        // window edges
        step(1'b1, 16'h80FF, 1'b0, "R2");
        step(1'b1, 16'h2000, 1'b0, "R2");
        step(1'b1, 16'h1FFF, 1'b0, "R2");
        step(1'b0, 16'h0, 1'b1, "R7");
        step(1'b1, 16'h8100, 1'b0, "R2");
        step(1'b0, 16'h0, 1'b1, "R7");

        // run length 4, broken run
        persist_sel = 2'd1;
        out_run(3, "R4");
        step(1'b1, 16'h4000, 1'b0, "R4");
        out_run(3, "R4");
        out_run(1, "R3");
        step(1'b0, 16'h0, 1'b1, "R7");

        // idle gaps do not break a run
        out_run(2, "R5");
        repeat (5) step(1'b0, 16'hFFFF, 1'b0, "R5");
        out_run(2, "R5");
        step(1'b0, 16'h0, 1'b1, "R7");

        // run length 8 and 16
        persist_sel = 2'd2;
        out_run(7, "R3");
        out_run(1, "R3");
        step(1'b0, 16'h0, 1'b1, "R7");
        persist_sel = 2'd3;
        out_run(15, "R3");
        out_run(1, "R3");

        // results while latched are ignored
        out_run(3, "R10");
        step(1'b0, 16'h0, 1'b1, "R10");
        persist_sel = 2'd1;
        out_run(3, "R10");
        out_run(1, "R10");

        // clear meets a qualifying strobe
        persist_sel = 2'd0;
        step(1'b1, 16'hF000, 1'b1, "R7");
        persist_sel = 2'd1;
        step(1'b1, 16'hF000, 1'b1, "R7");
        out_run(2, "R7");
        out_run(1, "R7");
        step(1'b0, 16'h0, 1'b1, "R7");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ((i % 97) == 0) persist_sel = 2'($urandom_range(0, 3));
            if ((i % 500) == 0) begin
                thr_upper = 8'($urandom_range(128, 250));
                thr_lower = 8'($urandom_range(5, 100));
            end
            rv = ($urandom_range(0, 1) == 1);
            rc = ($urandom_range(0, 99) < 3);
            rm = 16'($urandom);
            if ($urandom_range(0, 3) != 0) rm[15:8] = 8'($urandom_range(251, 255));
            step(rv, rm, rc, "R3 R4 R5 R6 R7");
        end

        rst = 1'b1;
        step(1'b0, 16'h0, 1'b0, "R1");
        rst = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule